// File: doc/BRIEF.md
# Serial-scan to system-bus access bridge

This block sits behind a boundary-scan TAP controller and turns data-register scans into single-beat accesses on a bus master port. The TAP supplies the test clock and its capture, shift and update strobes, together with a select line. The select line is high while the debug instruction is loaded and the bus chain is chosen. During a shift the block assembles a command frame. The frame carries a target address, a direction bit, a write word and a checksum. On the update strobe the block checks the frame's length and checksum. A frame that passes is handed across to the bus clock, where one bus cycle is run to completion. That cycle may contain any number of slave wait states.

The result of a read is not returned in the scan that issued it. The bus-side result register is loaded into the scan register at the following capture. The host therefore reads the data out during its next scan, which is usually the next command. A status bit at the front of that returned frame reports whether the last access ended in an error response. The test-clock side and the bus side pass control through a pair of toggle signals. Each toggle crosses a small synchronizer. Only one access can be outstanding at any time.

Top module: `jdb_bridge`

## Requirements
- R1: A command frame is shifted in least significant bit first and is 73 bits long. Bits 31:0 carry the address. Bit 32 is the direction, where 1 means write and 0 means read. Bits 64:33 carry the write word, which a read ignores. Bits 72:65 carry the checksum.
- R2: The checksum is an 8-bit CRC with polynomial x^8+x^2+x+1 (0x07) and initial value 0. It is computed one bit at a time in shift order over frame bits 0 to 64. For each bit the feedback is the register's top bit XOR the input bit. The register shifts left, and the polynomial is XORed in when the feedback is 1. A frame whose bits 72:65 differ from this value starts no bus cycle.
- R3: A bus cycle is started only by an update that follows exactly 73 shift clocks since the last capture. Frames of 72 or 74 bits start nothing.
- R4: An accepted frame produces exactly one bus cycle. The cycle carries the frame's address and direction. On a write it also drives the frame's word. The byte select is all ones and the burst output stays low.
- R5: The cycle and strobe outputs stay high, with address, write word and direction stable, until a cycle in which ack or err is seen. Both outputs are low in the cycle after that. Any number of wait states is accepted.
- R6: When the bus clock runs at least five times faster than the test clock and the slave inserts up to 4 wait states, a write has finished on the bus within 10 test clocks after the update.
- R7: Each capture loads the scan register with the last access's result. Bit 0 holds the error status and bits 32:1 hold the last successfully read word. These bits are the first 33 values seen on tdo during the next shift.
- R8: An err response sets the status bit and leaves the held read word unchanged. The next access that ends with ack clears the status bit. A write never changes the held read word.
- R9: While the select input is low, capture, shift and update have no effect and start no bus cycle.
- R10: An accepted update that arrives while the previous access is still outstanding is dropped. No second bus cycle follows it.
- R11: After reset, cyc, stb and we are low and tdo is low, and the first scan returns 33 zero bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock from the TAP |
| tck_rst | input | 1 | Synchronous active-high reset, test clock domain |
| dbg_sel | input | 1 | Debug instruction active and bus chain selected |
| dr_capture | input | 1 | TAP capture-DR strobe |
| dr_shift | input | 1 | TAP shift-DR strobe |
| dr_update | input | 1 | TAP update-DR strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (scan register bit 0) |
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, bus domain |
| bus_adr | output | 32 | Bus address |
| bus_dat_w | output | 32 | Bus write data |
| bus_dat_r | input | 32 | Bus read data |
| bus_cyc | output | 1 | Bus cycle valid |
| bus_stb | output | 1 | Bus strobe |
| bus_sel | output | 4 | Byte select, all ones |
| bus_we | output | 1 | Write enable |
| bus_ack | input | 1 | Slave acknowledge |
| bus_err | input | 1 | Slave error termination |
| bus_cab | output | 1 | Burst indication, held low |

## Verification
The update edge flips the request toggle. The bus side sees it two bus clocks later, and cyc rises on the next edge. The cycle ends on the edge after ack or err, and the done toggle reaches the test clock side two test clocks after that. The bench therefore runs ten idle test clocks after every update before it inspects its bus slave model's log. The result of a read becomes visible on tdo right after the capture edge of the next scan. The bench samples tdo while the test clock is low, before each shift edge, and compares the first 33 bits of the following scan with the value it expects. The bus slave model samples one time step after each bus clock edge, and there it checks that address, word and direction stay stable and that the cycle ends one edge after each ack or err.

// File: rtl/jdb_pkg.sv
`timescale 1ns/1ps
package jdb_pkg;

  typedef enum logic [0:0] {
    BUS_IDLE = 1'b0,
    BUS_WAIT = 1'b1
  } bus_state_t;

  function automatic int unsigned frame_bits(int unsigned aw, int unsigned dw, int unsigned cw);
    return aw + 1 + dw + cw;
  endfunction

endpackage

// File: rtl/jdb_sync.sv
`timescale 1ns/1ps
module jdb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= (pipe << 1) | STAGES'(d);
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/jdb_crc.sv
`timescale 1ns/1ps
module jdb_crc #(
  parameter int unsigned W    = 8,
  parameter logic [W-1:0] POLY = 'h07
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] crc
);
  logic         fb;
  logic [W-1:0] nxt;

  always_comb begin
    fb  = crc[W-1] ^ din;
    nxt = {crc[W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk) begin
    if (clr)     crc <= '0;
    else if (en) crc <= nxt;
  end
endmodule

// File: rtl/jdb_tck_side.sv
`timescale 1ns/1ps
module jdb_tck_side #(
  parameter int unsigned  AW     = 32,
  parameter int unsigned  DW     = 32,
  parameter int unsigned  CW     = 8,
  parameter logic [CW-1:0] POLY  = 'h07,
  parameter int unsigned  SYNC   = 2
) (
  input  logic          tck,
  input  logic          rst,
  input  logic          sel,
  input  logic          capture,
  input  logic          shift,
  input  logic          update,
  input  logic          tdi,
  output logic          tdo,
  input  logic          done_tgl_i,
  input  logic [DW-1:0] rd_data_i,
  input  logic          rd_err_i,
  output logic          req_tgl_o,
  output logic [AW-1:0] cmd_adr_o,
  output logic [DW-1:0] cmd_dat_o,
  output logic          cmd_we_o
);
  localparam int unsigned HDR   = AW + 1 + DW;
  localparam int unsigned FL    = jdb_pkg::frame_bits(AW, DW, CW);
  localparam int unsigned CNT_W = $clog2(FL + 2);

  logic [FL-1:0]    sr;
  logic [CNT_W-1:0] cnt;
  logic [CW-1:0]    crc;
  logic             done_s;
  logic             busy;
  logic             frame_ok;
  logic             crc_en;
  logic             crc_clr;

  jdb_sync #(.STAGES(SYNC)) u_done_sync (
    .clk (tck),
    .rst (rst),
    .d   (done_tgl_i),
    .q   (done_s)
  );

  assign crc_en  = sel & shift & (cnt < CNT_W'(HDR));
  assign crc_clr = rst | (sel & capture);

  jdb_crc #(.W(CW), .POLY(POLY)) u_crc (
    .clk (tck),
    .clr (crc_clr),
    .en  (crc_en),
    .din (tdi),
    .crc (crc)
  );

  assign busy     = req_tgl_o ^ done_s;
  assign frame_ok = (cnt == CNT_W'(FL)) && (sr[FL-1 -: CW] == crc);

  always_ff @(posedge tck) begin
    if (rst) begin
      sr        <= '0;
      cnt       <= '0;
      req_tgl_o <= 1'b0;
      cmd_adr_o <= '0;
      cmd_dat_o <= '0;
      cmd_we_o  <= 1'b0;
    end else begin
      if (sel && capture) begin
        // bus-side result is only stable (safe to sample) while idle
        sr  <= busy ? '0 : {{(FL-DW-1){1'b0}}, rd_data_i, rd_err_i};
        cnt <= '0;
      end else if (sel && shift) begin
        sr <= {tdi, sr[FL-1:1]};
        if (cnt != CNT_W'(FL + 1)) cnt <= cnt + 1'b1;
      end
      if (sel && update && frame_ok && !busy) begin
        req_tgl_o <= ~req_tgl_o;
        cmd_adr_o <= sr[AW-1:0];
        cmd_we_o  <= sr[AW];
        cmd_dat_o <= sr[AW+1 +: DW];
      end
    end
  end

  assign tdo = sr[0];

  // R3: a frame of the wrong length never raises a request
  a_r3_len_gate: assert property (@(posedge tck) disable iff (rst)
    (sel && update && (cnt != CNT_W'(FL))) |=> $stable(req_tgl_o));

  // R10: an update while busy is dropped
  a_r10_busy_drop: assert property (@(posedge tck) disable iff (rst)
    (update && busy) |=> $stable(req_tgl_o));

  // R9: the request toggles only on a selected update
  a_r9_req_needs_sel: assert property (@(posedge tck) disable iff (rst)
    !$stable(req_tgl_o) |-> ($past(update) && $past(sel)));
endmodule

// File: rtl/jdb_bus_side.sv
`timescale 1ns/1ps
module jdb_bus_side #(
  parameter int unsigned AW   = 32,
  parameter int unsigned DW   = 32,
  parameter int unsigned SYNC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_tgl_i,
  input  logic [AW-1:0] cmd_adr_i,
  input  logic [DW-1:0] cmd_dat_i,
  input  logic          cmd_we_i,
  output logic [AW-1:0] adr_o,
  output logic [DW-1:0] dat_o,
  input  logic [DW-1:0] dat_i,
  output logic          cyc_o,
  output logic          stb_o,
  output logic          we_o,
  input  logic          ack_i,
  input  logic          err_i,
  output logic          done_tgl_o,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_err_o
);
  import jdb_pkg::*;

  bus_state_t state;
  logic       req_s;
  logic       req_seen;
  logic       start;
  logic       term;

  jdb_sync #(.STAGES(SYNC)) u_req_sync (
    .clk (clk),
    .rst (rst),
    .d   (req_tgl_i),
    .q   (req_s)
  );

  assign start = (state == BUS_IDLE) && (req_s ^ req_seen);
  assign term  = ack_i | err_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= BUS_IDLE;
      req_seen   <= 1'b0;
      adr_o      <= '0;
      dat_o      <= '0;
      we_o       <= 1'b0;
      cyc_o      <= 1'b0;
      stb_o      <= 1'b0;
      done_tgl_o <= 1'b0;
      rd_data_o  <= '0;
      rd_err_o   <= 1'b0;
    end else begin
      case (state)
        BUS_IDLE: begin
          if (start) begin
            req_seen <= req_s;
            adr_o    <= cmd_adr_i;
            dat_o    <= cmd_dat_i;
            we_o     <= cmd_we_i;
            cyc_o    <= 1'b1;
            stb_o    <= 1'b1;
            state    <= BUS_WAIT;
          end
        end
        BUS_WAIT: begin
          if (term) begin
            cyc_o      <= 1'b0;
            stb_o      <= 1'b0;
            rd_err_o   <= err_i;
            if (!we_o && !err_i) rd_data_o <= dat_i;
            done_tgl_o <= ~done_tgl_o;
            state      <= BUS_IDLE;
          end
        end
        default: state <= BUS_IDLE;
      endcase
    end
  end

  // R5: outputs held until the slave terminates
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (cyc_o && !ack_i && !err_i) |=>
      (cyc_o && stb_o && $stable(adr_o) && $stable(dat_o) && $stable(we_o)));

  // R5: single beat, released right after termination
  a_r5_single_beat: assert property (@(posedge clk) disable iff (rst)
    (cyc_o && term) |=> (!cyc_o && !stb_o));

  // R4: a cycle begins only from a fresh request
  a_r4_start_from_req: assert property (@(posedge clk) disable iff (rst)
    $rose(cyc_o) |-> $past(start));

  // R4: completion is reported only for a cycle that ran
  a_r4_done_after_cycle: assert property (@(posedge clk) disable iff (rst)
    !$stable(done_tgl_o) |-> $past(cyc_o));
endmodule

// File: rtl/jdb_bridge.sv
`timescale 1ns/1ps
module jdb_bridge #(
  parameter int unsigned   ADDR_W      = 32,
  parameter int unsigned   DATA_W      = 32,
  parameter int unsigned   CRC_W       = 8,
  parameter logic [CRC_W-1:0] CRC_POLY = 8'h07,
  parameter int unsigned   SYNC_STAGES = 2
) (
  input  logic                  tck,
  input  logic                  tck_rst,
  input  logic                  dbg_sel,
  input  logic                  dr_capture,
  input  logic                  dr_shift,
  input  logic                  dr_update,
  input  logic                  tdi,
  output logic                  tdo,
  input  logic                  clk,
  input  logic                  rst,
  output logic [ADDR_W-1:0]     bus_adr,
  output logic [DATA_W-1:0]     bus_dat_w,
  input  logic [DATA_W-1:0]     bus_dat_r,
  output logic                  bus_cyc,
  output logic                  bus_stb,
  output logic [DATA_W/8-1:0]   bus_sel,
  output logic                  bus_we,
  input  logic                  bus_ack,
  input  logic                  bus_err,
  output logic                  bus_cab
);
  localparam int unsigned SEL_W = DATA_W / 8;

  logic              req_tgl;
  logic              done_tgl;
  logic [ADDR_W-1:0] cmd_adr;
  logic [DATA_W-1:0] cmd_dat;
  logic              cmd_we;
  logic [DATA_W-1:0] rd_data;
  logic              rd_err;

  jdb_tck_side #(
    .AW(ADDR_W), .DW(DATA_W), .CW(CRC_W), .POLY(CRC_POLY), .SYNC(SYNC_STAGES)
  ) u_tck (
    .tck        (tck),
    .rst        (tck_rst),
    .sel        (dbg_sel),
    .capture    (dr_capture),
    .shift      (dr_shift),
    .update     (dr_update),
    .tdi        (tdi),
    .tdo        (tdo),
    .done_tgl_i (done_tgl),
    .rd_data_i  (rd_data),
    .rd_err_i   (rd_err),
    .req_tgl_o  (req_tgl),
    .cmd_adr_o  (cmd_adr),
    .cmd_dat_o  (cmd_dat),
    .cmd_we_o   (cmd_we)
  );

  jdb_bus_side #(
    .AW(ADDR_W), .DW(DATA_W), .SYNC(SYNC_STAGES)
  ) u_bus (
    .clk        (clk),
    .rst        (rst),
    .req_tgl_i  (req_tgl),
    .cmd_adr_i  (cmd_adr),
    .cmd_dat_i  (cmd_dat),
    .cmd_we_i   (cmd_we),
    .adr_o      (bus_adr),
    .dat_o      (bus_dat_w),
    .dat_i      (bus_dat_r),
    .cyc_o      (bus_cyc),
    .stb_o      (bus_stb),
    .we_o       (bus_we),
    .ack_i      (bus_ack),
    .err_i      (bus_err),
    .done_tgl_o (done_tgl),
    .rd_data_o  (rd_data),
    .rd_err_o   (rd_err)
  );

  assign bus_sel = {SEL_W{1'b1}};
  assign bus_cab = 1'b0;
endmodule

// File: tb/jdb_bridge_tb_top.sv
`timescale 1ns/1ps
module jdb_bridge_tb_top;
  localparam logic [31:0] RKEY = 32'h5A5A_C3C3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tck = 1'b0;
  logic        tck_rst = 1'b1;
  logic        dbg_sel = 1'b0;
  logic        dr_capture = 1'b0;
  logic        dr_shift = 1'b0;
  logic        dr_update = 1'b0;
  logic        tdi = 1'b0;
  logic        tdo;
  logic [31:0] bus_adr;
  logic [31:0] bus_dat_w;
  logic [31:0] bus_dat_r;
  logic        bus_cyc;
  logic        bus_stb;
  logic [3:0]  bus_sel;
  logic        bus_we;
  logic        bus_ack;
  logic        bus_err;
  logic        bus_cab;

  int n_chk = 0;
  int n_fail = 0;

  // slave model state
  int          ws = 0;
  logic        err_mode = 1'b0;
  int          acc_cnt = 0;
  int          proto_err = 0;
  logic [31:0] last_adr = '0;
  logic [31:0] last_wdat = '0;
  logic        last_we = 1'b0;
  logic [3:0]  last_sel = '0;
  logic        last_cab = 1'b0;

  logic [72:0] sout;

  jdb_bridge dut_i (
    .tck(tck), .tck_rst(tck_rst), .dbg_sel(dbg_sel),
    .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update),
    .tdi(tdi), .tdo(tdo), .clk(clk), .rst(rst),
    .bus_adr(bus_adr), .bus_dat_w(bus_dat_w), .bus_dat_r(bus_dat_r),
    .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_ack(bus_ack), .bus_err(bus_err), .bus_cab(bus_cab)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [72:0] mk(input logic [31:0] a, input logic w, input logic [31:0] d);
    logic [64:0] h;
    logic [7:0]  c;
    h = {d, w, a};
    c = 8'h00;
    for (int i = 0; i < 65; i++) begin
      bit fb;
      fb = c[7] ^ h[i];
      c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return {c, h};
  endfunction

  task automatic tpulse();
    #10 tck = 1'b1;
    #20 tck = 1'b0;
    #10;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tpulse();
  endtask

  task automatic scan(input logic [72:0] f, input int nb, input logic s);
    dbg_sel = s;
    dr_capture = 1'b1;
    tpulse();
    dr_capture = 1'b0;
    sout = '0;
    dr_shift = 1'b1;
    for (int i = 0; i < nb; i++) begin
      tdi = (i < 73) ? f[i] : 1'b0;
      if (i < 73) sout[i] = tdo;
      tpulse();
    end
    dr_shift = 1'b0;
    dr_update = 1'b1;
    tpulse();
    dr_update = 1'b0;
    dbg_sel = 1'b1;
  endtask

  task automatic cmd(input logic [31:0] a, input logic w, input logic [31:0] d);
    scan(mk(a, w, d), 73, 1'b1);
    idle(10);
  endtask

  // bus slave model with wait states and protocol monitor
  initial begin
    logic        pc;
    logic [31:0] pa, pd;
    logic        pw;
    int          wcnt;
    bus_ack = 1'b0; bus_err = 1'b0; bus_dat_r = '0;
    wcnt = 0; pc = 1'b0; pa = '0; pd = '0; pw = 1'b0;
    forever begin
      @(posedge clk); #1;
      if (!rst) begin
        if (bus_stb !== bus_cyc) proto_err++;
        if (bus_ack || bus_err) begin
          if (bus_cyc) proto_err++;           // R5 release after termination
          bus_ack = 1'b0; bus_err = 1'b0; bus_dat_r = '0; wcnt = 0;
        end else if (bus_cyc) begin
          if (pc && (bus_adr !== pa || bus_dat_w !== pd || bus_we !== pw)) proto_err++;
          if (wcnt >= ws) begin
            if (err_mode) bus_err = 1'b1;
            else begin
              bus_ack = 1'b1;
              if (!bus_we) bus_dat_r = bus_adr ^ RKEY;
            end
            acc_cnt++;
            last_adr = bus_adr; last_wdat = bus_dat_w; last_we = bus_we;
            last_sel = bus_sel; last_cab = bus_cab;
          end else wcnt++;
        end
        pc = bus_cyc; pa = bus_adr; pd = bus_dat_w; pw = bus_we;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", n_chk, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] exp_rd;
    logic [72:0] f;
    int          a0;

    idle(3);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    tck_rst = 1'b0;
    dbg_sel = 1'b1;
    idle(2);

    // R11: reset state
    chk("R11 cyc/stb/we", {61'd0, bus_cyc, bus_stb, bus_we}, 64'd0);
    chk("R11 tdo", {63'd0, tdo}, 64'd0);
    chk("R4 sel/cab static", {59'd0, bus_sel, bus_cab}, {59'd0, 4'hF, 1'b0});

    // R7: chained reads, each scan returns the previous read word
    ws = 0;
    cmd(32'h0000_1000, 1'b0, 32'hFFFF_FFFF);
    chk("R11 first scan zero", {31'd0, sout[32:0]}, 64'd0);
    chk("R4 read issued", {32'd0, last_adr}, {32'd0, 32'h0000_1000});
    exp_rd = 32'h0000_1000 ^ RKEY;
    for (int i = 1; i <= 5; i++) begin
      logic [31:0] a;
      a = 32'h8000_0003 + 32'(i) * 32'h0101_0404;
      ws = i;
      a0 = acc_cnt;
      cmd(a, 1'b0, 32'(i));
      chk("R7 read word", {32'd0, sout[32:1]}, {32'd0, exp_rd});
      chk("R7 status clear", {63'd0, sout[0]}, 64'd0);
      chk("R4 one read cycle", 64'(acc_cnt - a0), 64'd1);
      chk("R1 read direction", {63'd0, last_we}, 64'd0);
      exp_rd = a ^ RKEY;
    end

    // R4/R6: write sweep over address, data and wait states
    for (int i = 0; i < 8; i++) begin
      logic [31:0] a, d;
      a = 32'hC000_0000 | (32'(i) << 4) | 32'(i * 7);
      d = 32'hDEAD_0000 ^ (32'h1111_1111 * 32'(i));
      ws = i % 5;
      a0 = acc_cnt;
      cmd(a, 1'b1, d);
      chk("R6 write done in 10 tck", 64'(acc_cnt - a0), 64'd1);
      chk("R4 write addr", {32'd0, last_adr}, {32'd0, a});
      chk("R4 write data", {32'd0, last_wdat}, {32'd0, d});
      chk("R1 write direction", {63'd0, last_we}, 64'd1);
      chk("R4 sel/cab", {59'd0, last_sel, last_cab}, {59'd0, 4'hF, 1'b0});
    end

    // R8: writes leave the held read word unchanged
    ws = 3;
    cmd(32'h0000_2222, 1'b0, 32'h0);
    chk("R8 word after writes", {32'd0, sout[32:1]}, {32'd0, exp_rd});
    exp_rd = 32'h0000_2222 ^ RKEY;

    // R8: error response sets status, keeps word
    err_mode = 1'b1;
    cmd(32'h0000_3333, 1'b0, 32'h0);
    err_mode = 1'b0;
    chk("R7 word before err", {32'd0, sout[32:1]}, {32'd0, exp_rd});
    cmd(32'h0000_4444, 1'b0, 32'h0);
    chk("R8 err status set", {63'd0, sout[0]}, 64'd1);
    chk("R8 word kept on err", {32'd0, sout[32:1]}, {32'd0, exp_rd});
    exp_rd = 32'h0000_4444 ^ RKEY;
    cmd(32'h0000_5555, 1'b0, 32'h0);
    chk("R8 err status cleared", {63'd0, sout[0]}, 64'd0);
    chk("R8 word after clear", {32'd0, sout[32:1]}, {32'd0, exp_rd});

    // R2: checksum mismatch
    a0 = acc_cnt;
    f = mk(32'h1234_5678, 1'b1, 32'hCAFE_F00D);
    f[65] = ~f[65];
    scan(f, 73, 1'b1); idle(10);
    chk("R2 bad crc bit", 64'(acc_cnt - a0), 64'd0);
    f = mk(32'h1234_5678, 1'b1, 32'hCAFE_F00D);
    f[40] = ~f[40];
    scan(f, 73, 1'b1); idle(10);
    chk("R2 corrupted data", 64'(acc_cnt - a0), 64'd0);

    // R3: wrong lengths
    f = mk(32'h1234_5678, 1'b1, 32'hCAFE_F00D);
    scan(f, 72, 1'b1); idle(10);
    chk("R3 short frame", 64'(acc_cnt - a0), 64'd0);
    scan(f, 74, 1'b1); idle(10);
    chk("R3 long frame", 64'(acc_cnt - a0), 64'd0);

    // R9: not selected
    scan(f, 73, 1'b0); idle(10);
    chk("R9 unselected scan", 64'(acc_cnt - a0), 64'd0);
    scan(f, 73, 1'b1); idle(10);
    chk("R2 good crc accepted", 64'(acc_cnt - a0), 64'd1);
    chk("R2 good crc addr", {32'd0, last_adr}, {32'd0, 32'h1234_5678});

    // R10: update while busy is dropped
    ws = 800;
    a0 = acc_cnt;
    cmd(32'hB000_0001, 1'b1, 32'h0000_0001);
    cmd(32'hB000_0002, 1'b1, 32'h0000_0002);
    idle(200);
    chk("R10 one cycle only", 64'(acc_cnt - a0), 64'd1);
    chk("R10 first kept", {32'd0, last_adr}, {32'd0, 32'hB000_0001});
    ws = 0;
    cmd(32'hB000_0003, 1'b1, 32'h0000_0003);
    chk("R10 next accepted", 64'(acc_cnt - a0), 64'd2);
    chk("R10 next addr", {32'd0, last_adr}, {32'd0, 32'hB000_0003});

    // R5: protocol monitor over the whole run
    chk("R5 hold/release", 64'(proto_err), 64'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule